// File: doc/BRIEF.md
# Configurable Word-Level Array Processing Element

This block is the compute element of one tile in a coarse-grained reconfigurable array. Each clock it takes two 16-bit words and two single-bit signals from the routing fabric. It runs one configured operation and presents a registered 16-bit word result and a registered 1-bit result to the fabric. The operation is chosen by a configuration register. That register picks an integer ALU function or the multiplier, the source of each operand (either routed input or a per-operand constant), signed or unsigned treatment, the meaning of the condition flag, and an 8-entry truth table that forms the bit result.

Configuration and its two constants are captured in one clock when the configuration strobe is high. They then stay fixed until the next strobe. A fixed coefficient such as a filter weight can therefore sit in a constant, so the fabric routes one fewer signal. The block has no state machine. It has two registered stages: the held configuration, and the output register that follows a single combinational path (operand select, then the ALU or the multiplier, then the output select).

Top module: `cgra_word_pe`

## Requirements
- R1: After reset both outputs are 0. The held configuration is all zero: op code 0 (ADD), both operands from `in0`, truth table 0, unsigned, flag shows the comparison, both constants 0.
- R2: When `cfg_we` is high at a rising edge, all configuration inputs are captured and govern results from the next edge on. When `cfg_we` is low, changes on the configuration inputs have no effect.
- R3: `word_out` and `bit_out` change only at a rising edge. They reflect the operands and bit inputs present at that edge.
- R4: Operand source codes apply to both operands: 0 selects `in0`, 1 selects `in1`, and 2 or 3 selects the operand's own constant. Operand A uses `cfg_k0` and operand B uses `cfg_k1`. So either input can feed either operand.
- R5: Op codes 0 ADD (A+B), 1 SUB (A-B), 2 add-with-carry (A+B+`bit_in0`) and 3 subtract-with-borrow (A-B-`bit_in0`) give the low 16 bits. Their carry-out, or for subtraction their borrow-out (1 when the true difference is negative), is the raw carry value.
- R6: Op code 5 shifts A right and op code 6 shifts A left, by B[3:0]. The right shift fills with zeros in unsigned mode and with A[15] in signed mode.
- R7: Op codes 7, 8 and 9 give bitwise OR, AND and XOR of A and B.
- R8: Op code 10 gives the larger operand and op code 11 the smaller. A wins a tie in both cases. The compare uses two's-complement order in signed mode (`cfg_signed`=1) and unsigned order otherwise.
- R9: Op code 4 (select) returns A when `bit_in1` is 1 and B otherwise.
- R10: With `cfg_mul`=1 the word result is the low 16 bits of A×B, whatever the op code.
- R11: With `cfg_flag_carry`=1 the flag is the raw carry value of op codes 0 to 3 and 0 for all other codes. With `cfg_flag_carry`=0 the flag is: A<=B for code 11, `bit_in1` for code 4, and A>=B (signed per mode) for the other defined codes.
- R12: `bit_out` is entry {flag, `bit_in1`, `bit_in0`} of the truth table, with the flag as the most significant index bit.
- R13: Op codes 12 to 15 give a word result of 0 and a flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration capture strobe |
| cfg_op | input | 4 | ALU op code |
| cfg_mul | input | 1 | 1 routes the multiplier to the word output |
| cfg_asrc | input | 2 | Operand A source code |
| cfg_bsrc | input | 2 | Operand B source code |
| cfg_lut | input | 8 | Truth table for the bit output |
| cfg_signed | input | 1 | Signed mode for compares and right shift |
| cfg_flag_carry | input | 1 | 1 selects carry/borrow as the flag |
| cfg_k0 | input | 16 | Constant for operand A |
| cfg_k1 | input | 16 | Constant for operand B |
| in0 | input | 16 | Routed data input 0 |
| in1 | input | 16 | Routed data input 1 |
| bit_in0 | input | 1 | Carry/borrow input, truth-table index bit 0 |
| bit_in1 | input | 1 | Select input, truth-table index bit 1 |
| word_out | output | 16 | Registered word result |
| bit_out | output | 1 | Registered bit result |

## Verification
The bench targets the edges where a wrong design shows itself. It drives a carry-in into 0xFFFF, which would lose the carry if the flag were taken from the 16-bit sum. It uses a borrow below zero, which a design that sets the flag on the wrong sign would report inverted. It compares 0x8000 against a small positive value in both signed modes, where a mixed-up compare picks the wrong operand. It shifts with an amount whose upper bits are set, which a design that forgot to mask would turn into zero. It also checks operand swapping for subtraction and both constant source codes, and looks at a tie on min. It toggles the configuration inputs while the strobe is low, and a design that leaked them would change its results there. It checks that the output stays put when inputs change between edges, which would expose a combinational path to the ports.

// File: rtl/cgra_pe_pkg.sv
package cgra_pe_pkg;
    localparam int PE_W   = 16;
    localparam int OP_W   = 4;
    localparam int SRC_W  = 2;
    localparam int LUT_IN = 3;
    localparam int LUT_N  = 1 << LUT_IN;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_SBB = 4'd3,
        OP_SEL = 4'd4,
        OP_SHR = 4'd5,
        OP_SHL = 4'd6,
        OP_OR  = 4'd7,
        OP_AND = 4'd8,
        OP_XOR = 4'd9,
        OP_MAX = 4'd10,
        OP_MIN = 4'd11
    } alu_op_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_IN0   = 2'd0,
        SRC_IN1   = 2'd1,
        SRC_CONST = 2'd2,
        SRC_CALT  = 2'd3
    } src_sel_e;

    typedef struct packed {
        alu_op_e           op;
        logic              use_mul;
        src_sel_e          a_src;
        src_sel_e          b_src;
        logic [LUT_N-1:0]  lut;
        logic              sgn;
        logic              flag_carry;
        logic [PE_W-1:0]   k0;
        logic [PE_W-1:0]   k1;
    } pe_cfg_t;
endpackage

// File: rtl/cgra_pe_cfg.sv
module cgra_pe_cfg
    import cgra_pe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    we,
    input  pe_cfg_t cfg_d,
    output pe_cfg_t cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_d;
        end
    end

    // R2: configuration is frozen while the strobe is low
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));

    // R2: a strobe captures the presented configuration
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(cfg_d)));
endmodule

// File: rtl/cgra_pe_opsel.sv
module cgra_pe_opsel
    import cgra_pe_pkg::*;
#(
    parameter int W = PE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  src_sel_e     sel,
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] konst,
    output logic [W-1:0] opnd
);
    always_comb begin
        unique case (sel)
            SRC_IN0:   opnd = in0;
            SRC_IN1:   opnd = in1;
            SRC_CONST,
            SRC_CALT:  opnd = konst;
            default:   opnd = in0;
        endcase
    end

    // R4: both constant codes route the constant, never a routed input
    p_const_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_CONST || sel == SRC_CALT) |-> (opnd == konst));
endmodule

// File: rtl/cgra_pe_alu.sv
module cgra_pe_alu
    import cgra_pe_pkg::*;
#(
    parameter int W = PE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  alu_op_e      op,
    input  logic         sgn,
    input  logic         flag_carry,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sel_bit,
    output logic [W-1:0] res,
    output logic         flag
);
    localparam int SH = $clog2(W);

    logic [W:0]    add_x;
    logic [W:0]    sub_x;
    logic [SH-1:0] amt;
    logic          ge_c;
    logic          le_c;
    logic          cy;
    logic          cmp;
    logic          cin_add;
    logic          cin_sub;

    always_comb begin
        cin_add = (op == OP_ADC) ? cin : 1'b0;
        cin_sub = (op == OP_SBB) ? cin : 1'b0;
        add_x   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_add};
        sub_x   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_sub};
        amt     = b[SH-1:0];
        ge_c    = sgn ? ($signed(a) >= $signed(b)) : (a >= b);
        le_c    = sgn ? ($signed(a) <= $signed(b)) : (a <= b);
    end

    always_comb begin
        res = '0;
        cy  = 1'b0;
        cmp = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res = add_x[W-1:0];
                cy  = add_x[W];
                cmp = ge_c;
            end
            OP_SUB, OP_SBB: begin
                res = sub_x[W-1:0];
                cy  = sub_x[W];
                cmp = ge_c;
            end
            OP_SEL: begin
                res = sel_bit ? a : b;
                cmp = sel_bit;
            end
            OP_SHR: begin
                res = sgn ? $unsigned($signed(a) >>> amt) : (a >> amt);
                cmp = ge_c;
            end
            OP_SHL: begin
                res = a << amt;
                cmp = ge_c;
            end
            OP_OR: begin
                res = a | b;
                cmp = ge_c;
            end
            OP_AND: begin
                res = a & b;
                cmp = ge_c;
            end
            OP_XOR: begin
                res = a ^ b;
                cmp = ge_c;
            end
            OP_MAX: begin
                res = ge_c ? a : b;
                cmp = ge_c;
            end
            OP_MIN: begin
                res = le_c ? a : b;
                cmp = le_c;
            end
            default: begin
                res = '0;
                cy  = 1'b0;
                cmp = 1'b0;
            end
        endcase
        flag = flag_carry ? cy : cmp;
    end

    // R8: max always returns one of its operands
    p_max_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MAX) |-> (res == a || res == b));

    // R8: a raised min compare flag means A was chosen
    p_min_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MIN && !flag_carry && flag) |-> (res == a));

    // R13: unused op codes are inert
    p_undef_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op > OP_MIN) |-> (res == '0 && !flag));

    // R11: carry flag mode yields 0 for non-arithmetic codes
    p_carry_only_arith_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_carry && op > OP_SBB) |-> !flag);
endmodule

// File: rtl/cgra_word_pe.sv
module cgra_word_pe
    import cgra_pe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_op,
    input  logic        cfg_mul,
    input  logic [1:0]  cfg_asrc,
    input  logic [1:0]  cfg_bsrc,
    input  logic [7:0]  cfg_lut,
    input  logic        cfg_signed,
    input  logic        cfg_flag_carry,
    input  logic [15:0] cfg_k0,
    input  logic [15:0] cfg_k1,
    input  logic [15:0] in0,
    input  logic [15:0] in1,
    input  logic        bit_in0,
    input  logic        bit_in1,
    output logic [15:0] word_out,
    output logic        bit_out
);
    localparam int W = PE_W;

    pe_cfg_t            cfg_d;
    pe_cfg_t            cfg_q;
    logic [W-1:0]       opa;
    logic [W-1:0]       opb;
    logic [W-1:0]       alu_res;
    logic [W-1:0]       mul_res;
    logic [W-1:0]       word_d;
    logic               flag;
    logic [LUT_IN-1:0]  lut_idx;

    always_comb begin
        cfg_d.op         = alu_op_e'(cfg_op);
        cfg_d.use_mul    = cfg_mul;
        cfg_d.a_src      = src_sel_e'(cfg_asrc);
        cfg_d.b_src      = src_sel_e'(cfg_bsrc);
        cfg_d.lut        = cfg_lut;
        cfg_d.sgn        = cfg_signed;
        cfg_d.flag_carry = cfg_flag_carry;
        cfg_d.k0         = cfg_k0;
        cfg_d.k1         = cfg_k1;
    end

    cgra_pe_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    cgra_pe_opsel #(.W(W)) u_sel_a (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_q.a_src),
        .in0   (in0),
        .in1   (in1),
        .konst (cfg_q.k0),
        .opnd  (opa)
    );

    cgra_pe_opsel #(.W(W)) u_sel_b (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_q.b_src),
        .in0   (in0),
        .in1   (in1),
        .konst (cfg_q.k1),
        .opnd  (opb)
    );

    cgra_pe_alu #(.W(W)) u_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (cfg_q.op),
        .sgn        (cfg_q.sgn),
        .flag_carry (cfg_q.flag_carry),
        .a          (opa),
        .b          (opb),
        .cin        (bit_in0),
        .sel_bit    (bit_in1),
        .res        (alu_res),
        .flag       (flag)
    );

    always_comb begin
        mul_res = opa * opb;
        word_d  = cfg_q.use_mul ? mul_res : alu_res;
        lut_idx = {flag, bit_in1, bit_in0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out <= '0;
            bit_out  <= 1'b0;
        end else begin
            word_out <= word_d;
            bit_out  <= cfg_q.lut[lut_idx];
        end
    end

    // R12: an all-ones table forces the bit output high on the next edge
    p_lut_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lut == '1) |=> bit_out);

    // R12: an all-zero table forces the bit output low on the next edge
    p_lut_zeros_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lut == '0) |=> !bit_out);

    // R10: multiplying by one passes operand A to the word output
    p_mul_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.use_mul && opb == 16'd1) |=> (word_out == $past(opa)));
endmodule

// File: tb/cgra_word_pe_bench.sv
module cgra_word_pe_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_op;
    logic        cfg_mul;
    logic [1:0]  cfg_asrc;
    logic [1:0]  cfg_bsrc;
    logic [7:0]  cfg_lut;
    logic        cfg_signed;
    logic        cfg_flag_carry;
    logic [15:0] cfg_k0;
    logic [15:0] cfg_k1;
    logic [15:0] in0;
    logic [15:0] in1;
    logic        bit_in0;
    logic        bit_in1;
    logic [15:0] word_out;
    logic        bit_out;

    int n_run  = 0;
    int n_fail = 0;

    int       m_op, m_as, m_bs;
    bit       m_mul, m_sgn, m_fc;
    bit [7:0] m_lut;
    bit [15:0] m_k0, m_k1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgra_word_pe u_cgra_word_pe (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_mul(cfg_mul), .cfg_asrc(cfg_asrc), .cfg_bsrc(cfg_bsrc),
        .cfg_lut(cfg_lut), .cfg_signed(cfg_signed),
        .cfg_flag_carry(cfg_flag_carry), .cfg_k0(cfg_k0), .cfg_k1(cfg_k1),
        .in0(in0), .in1(in1), .bit_in0(bit_in0), .bit_in1(bit_in1),
        .word_out(word_out), .bit_out(bit_out)
    );

    function automatic void ref_eval(output bit [15:0] w, output bit bo);
        bit [15:0] a, b, alu;
        int ia, ib, sa, sb, t, sh;
        longint p;
        bit ge, le, cy, cmp, flag;
        a  = (m_as == 0) ? in0 : (m_as == 1) ? in1 : m_k0;
        b  = (m_bs == 0) ? in0 : (m_bs == 1) ? in1 : m_k1;
        ia = a; ib = b;
        sa = int'($signed(a)); sb = int'($signed(b));
        ge = m_sgn ? (sa >= sb) : (ia >= ib);
        le = m_sgn ? (sa <= sb) : (ia <= ib);
        sh = ib % 16;
        alu = 0; cy = 0; cmp = ge;
        case (m_op)
            0:  begin t = ia + ib;           alu = t[15:0]; cy = (t > 65535); end
            2:  begin t = ia + ib + bit_in0; alu = t[15:0]; cy = (t > 65535); end
            1:  begin t = ia - ib;           alu = t[15:0]; cy = (t < 0); end
            3:  begin t = ia - ib - bit_in0; alu = t[15:0]; cy = (t < 0); end
            4:  begin alu = bit_in1 ? a : b; cmp = bit_in1; end
            5:  begin t = m_sgn ? (sa >>> sh) : (ia >> sh); alu = t[15:0]; end
            6:  begin t = ia << sh; alu = t[15:0]; end
            7:  alu = a | b;
            8:  alu = a & b;
            9:  alu = a ^ b;
            10: alu = ge ? a : b;
            11: begin alu = le ? a : b; cmp = le; end
            default: begin alu = 0; cmp = 0; end
        endcase
        flag = m_fc ? cy : cmp;
        p = longint'(ia) * longint'(ib);
        w  = m_mul ? p[15:0] : alu;
        bo = m_lut[{flag, bit_in1, bit_in0}];
    endfunction

    task automatic check(string tag, bit [15:0] ew, bit eb);
        n_run++;
        if (word_out !== ew || bit_out !== eb) begin
            n_fail++;
            $display("FAIL %s: word=%h bit=%b expected word=%h bit=%b",
                     tag, word_out, bit_out, ew, eb);
        end
    endtask

    task automatic tick(string tag);
        bit [15:0] ew;
        bit eb;
        ref_eval(ew, eb);
        if (cfg_we) begin
            m_op = cfg_op; m_mul = cfg_mul; m_as = cfg_asrc; m_bs = cfg_bsrc;
            m_lut = cfg_lut; m_sgn = cfg_signed; m_fc = cfg_flag_carry;
            m_k0 = cfg_k0; m_k1 = cfg_k1;
        end
        @(negedge clk);
        check(tag, ew, eb);
    endtask

    task automatic setcfg(int op, bit mul, int as, int bs, bit [7:0] lut,
                          bit sgn, bit fc, bit [15:0] k0, bit [15:0] k1);
        cfg_op = 4'(op); cfg_mul = mul; cfg_asrc = 2'(as); cfg_bsrc = 2'(bs);
        cfg_lut = lut; cfg_signed = sgn; cfg_flag_carry = fc;
        cfg_k0 = k0; cfg_k1 = k1;
        cfg_we = 1'b1;
        tick("R2 load");
        cfg_we = 1'b0;
    endtask

    task automatic vec(bit [15:0] a0, bit [15:0] a1, bit c0, bit c1, string tag);
        in0 = a0; in1 = a1; bit_in0 = c0; bit_in1 = c1;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_op = 0; cfg_mul = 0; cfg_asrc = 0;
        cfg_bsrc = 0; cfg_lut = 0; cfg_signed = 0; cfg_flag_carry = 0;
        cfg_k0 = 0; cfg_k1 = 0; in0 = 0; in1 = 0; bit_in0 = 0; bit_in1 = 0;
        m_op = 0; m_mul = 0; m_as = 0; m_bs = 0; m_lut = 0; m_sgn = 0;
        m_fc = 0; m_k0 = 0; m_k1 = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0, 1'b0);
        rst_n = 1'b1;
        // R1 defaults: ADD of in0 with itself, empty truth table
        vec(16'd5, 16'd9, 1'b1, 1'b1, "R1 default");
        vec(16'h8001, 16'd0, 1'b0, 1'b0, "R1 default");

        // R3: outputs do not follow inputs between edges
        in0 = 16'h1234;
        #2;
        n_run++;
        if (word_out !== 16'h0002) begin
            n_fail++;
            $display("FAIL R3: word=%h expected %h", word_out, 16'h0002);
        end
        tick("R3");

        // R5, R11, R12: add with carry flag, truth table = xor of index bits
        setcfg(0, 0, 0, 1, 8'b1001_0110, 0, 1, 0, 0);
        vec(16'hFFFF, 16'h0001, 0, 0, "R5 add wrap");
        vec(16'd1, 16'd2, 1, 0, "R5 add");
        setcfg(2, 0, 0, 1, 8'b1110_1000, 0, 1, 0, 0);
        vec(16'hFFFF, 16'h0000, 1, 0, "R5 adc carry");
        vec(16'd3, 16'd4, 1, 1, "R5 adc");
        // R4 swap: A=in1, B=in0
        setcfg(1, 0, 1, 0, 8'hF0, 0, 1, 0, 0);
        vec(16'd3, 16'd10, 0, 0, "R4 R5 sub swap");
        vec(16'd10, 16'd3, 0, 0, "R5 sub borrow");
        setcfg(3, 0, 0, 1, 8'hF0, 0, 1, 0, 0);
        vec(16'd0, 16'd0, 1, 0, "R5 sbb");
        vec(16'd9, 16'd4, 1, 0, "R5 sbb");
        // R11 compare flag on SUB
        setcfg(1, 0, 0, 1, 8'hF0, 1, 0, 0, 0);
        vec(16'hFFFF, 16'd1, 0, 0, "R11 signed ge");
        // R6 shifts, amount uses B[3:0]
        setcfg(5, 0, 0, 1, 8'h00, 0, 0, 0, 0);
        vec(16'h8000, 16'h0014, 0, 0, "R6 shr logical");
        setcfg(5, 0, 0, 1, 8'h00, 1, 0, 0, 0);
        vec(16'h8000, 16'h0014, 0, 0, "R6 shr arith");
        vec(16'h4000, 16'h0003, 0, 0, "R6 shr arith pos");
        setcfg(6, 0, 0, 1, 8'h00, 0, 0, 0, 0);
        vec(16'h00F1, 16'h00F4, 0, 0, "R6 shl");
        // R7 with constants (codes 2 and 3)
        setcfg(7, 0, 2, 3, 8'hAA, 0, 0, 16'hF0F0, 16'h0FF0);
        vec(16'h0, 16'hFFFF, 1, 0, "R7 R4 or const");
        setcfg(8, 0, 3, 2, 8'hAA, 0, 0, 16'hF0F0, 16'h0FF0);
        vec(16'h0, 16'hFFFF, 0, 1, "R7 R4 and const");
        setcfg(9, 0, 2, 1, 8'hAA, 0, 0, 16'hF0F0, 16'h0);
        vec(16'h0, 16'h0FF0, 1, 1, "R7 xor");
        // R8 max / min
        setcfg(10, 0, 0, 1, 8'hF0, 1, 0, 0, 0);
        vec(16'h8000, 16'h0001, 0, 0, "R8 max signed");
        setcfg(10, 0, 0, 1, 8'hF0, 0, 0, 0, 0);
        vec(16'h8000, 16'h0001, 0, 0, "R8 max unsigned");
        setcfg(11, 0, 0, 1, 8'hF0, 1, 0, 0, 0);
        vec(16'h8000, 16'h0001, 0, 0, "R8 min signed");
        vec(16'h0007, 16'h0007, 0, 0, "R8 min tie");
        setcfg(11, 0, 0, 1, 8'hF0, 0, 0, 0, 0);
        vec(16'h8000, 16'h0001, 0, 0, "R8 min unsigned");
        // R9 select
        setcfg(4, 0, 0, 1, 8'hCC, 0, 0, 0, 0);
        vec(16'hAAAA, 16'h5555, 0, 1, "R9 sel a");
        vec(16'hAAAA, 16'h5555, 0, 0, "R9 sel b");
        // R10 multiplier
        setcfg(0, 1, 0, 1, 8'h00, 0, 0, 0, 0);
        vec(16'h0100, 16'h0100, 0, 0, "R10 mul wrap");
        vec(16'h0003, 16'hFFFF, 0, 0, "R10 mul");
        setcfg(9, 1, 0, 3, 8'h00, 1, 0, 0, 16'd7);
        vec(16'h0011, 16'h0, 0, 0, "R10 mul const");
        // R13 undefined op codes
        setcfg(13, 0, 0, 1, 8'h0F, 0, 0, 0, 0);
        vec(16'h1234, 16'h4321, 0, 0, "R13 undef");
        setcfg(15, 0, 0, 1, 8'h0F, 0, 1, 0, 0);
        vec(16'hFFFF, 16'hFFFF, 1, 1, "R13 undef");
        // R2 ignored config changes while strobe low
        setcfg(0, 0, 0, 1, 8'h55, 0, 1, 0, 0);
        cfg_op = 4'd6; cfg_mul = 1; cfg_asrc = 2'd2; cfg_lut = 8'hFF;
        cfg_k0 = 16'hBEEF;
        vec(16'd20, 16'd22, 0, 0, "R2 ignore");
        vec(16'hFFF0, 16'h0020, 1, 0, "R2 ignore");
        // R12 index order {flag, bit_in1, bit_in0}
        setcfg(10, 0, 0, 1, 8'b0100_0000, 0, 0, 0, 0);
        vec(16'd5, 16'd1, 0, 1, "R12 index");
        vec(16'd5, 16'd1, 1, 0, "R12 index");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule